// File: doc/BRIEF.md
# Banked Register File Addressing Unit

This block is the data-memory side of a small 8-bit accumulator core. Each instruction carries a 7-bit register offset. Two bank-select bits in a status byte extend that offset to a 9-bit physical address. The block sorts every access into one of five regions:

- the status byte;
- a 16-byte window shared by all banks;
- per-bank special-function storage;
- per-bank general-purpose storage;
- an absent bank.

It then steers one synchronous write and one combinational read to the matching storage.

Software changes banks by writing the status byte through the ordinary write port, at offset 0x03. The new bank applies from the next clock cycle. The status byte is also brought out as a port, and a debug port shows the 9-bit physical address of the current access. The special-function registers are modelled as plain storage that clears on reset. General-purpose and shared storage have no reset.

The parameter `NUM_BANKS` sets how many of the four possible banks exist; the default is 3. Accesses to a bank that does not exist read zero and drop writes. The status byte and the shared window still respond in that case.

Top module: `banked_regfile`

## Requirements
- R1: During a clock edge with `rst_n` low, the status byte clears to 0x00, so bank 0 is selected. Every special-function location (offsets 0x00–0x1F) of every implemented bank also clears to 0x00.
- R2: `dbg_phys_addr` always equals {status bit 6, status bit 5, `reg_addr`}. Status bit 6 is the upper bank bit and bit 5 is the lower.
- R3: A write to the status byte changes the bank used from the next cycle on. A read in the same cycle as that write still uses the old bank.
- R4: Offset 0x03 reaches a single status byte in every bank. It is written whole and appears on `status_q` from the next cycle.
- R5: Offsets 0x70–0x7F reach one shared 16-byte region, whatever the bank bits hold. This includes an absent bank.
- R6: Offsets 0x00–0x1F, other than 0x03, are special-function storage. Each implemented bank has its own copy.
- R7: Offsets 0x20–0x6F are general-purpose storage. Each implemented bank has its own copy.
- R8: When the selected bank number is `NUM_BANKS` or higher, offsets 0x00–0x6F other than 0x03 read as 0x00. Writes to them change no stored value.
- R9: `rd_data` is a combinational read of the location at `reg_addr`. A write takes effect at the clock edge and is visible to a read in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write the selected location at the next edge |
| reg_addr | input | 7 | Register offset from the instruction |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `reg_addr` in the current bank |
| status_q | output | 8 | Current status byte (bank bits at 6:5) |
| dbg_phys_addr | output | 9 | Current 9-bit physical address |

## Verification
The hardest situation to reach is an access to the absent bank that is then read back through an implemented bank. Only that sequence shows that a dropped write left no trace. The stimulus first fills every bank by switching the status byte bank by bank. It then runs long random sequences in which status writes, including ones that select the absent bank, are mixed with reads and writes to the same offsets. A behavioural model tracks which locations hold known values, so that every later read of an affected offset in a real bank is compared. Directed steps place a bank switch and a read in the same cycle to expose the one-cycle bank latency.

// File: rtl/banked_rf_pkg.sv
// Shared types for the banked register file.
// Assumes: nothing beyond the region classification used by the decoder and top.
package banked_rf_pkg;

    // Region a given (bank, offset) pair resolves to
    typedef enum logic [2:0] {
        RGN_STATUS = 3'd0,
        RGN_SHARED = 3'd1,
        RGN_SFR    = 3'd2,
        RGN_GPR    = 3'd3,
        RGN_ABSENT = 3'd4
    } region_e;

endpackage

// File: rtl/rf_addr_decode.sv
// Classifies a banked access into one storage region.
// Assumes: SFR_SPAN <= STATUS_OFS is false (status lies inside the SFR span),
// SHARED_BASE lies above SFR_SPAN, and banks >= NUM_BANKS are absent.
module rf_addr_decode
    import banked_rf_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int BANK_W      = 2,
    parameter int NUM_BANKS   = 3,
    parameter int SFR_SPAN    = 32,
    parameter int SHARED_BASE = 112,
    parameter int STATUS_OFS  = 3
) (
    input  logic [BANK_W-1:0] bank,
    input  logic [ADDR_W-1:0] offset,
    output region_e           region
);

    // Priority: status mirror, shared mirror, absent bank, SFR, GPR
    always_comb begin
        if (int'(offset) == STATUS_OFS)
            region = RGN_STATUS;
        else if (int'(offset) >= SHARED_BASE)
            region = RGN_SHARED;
        else if (int'(bank) >= NUM_BANKS)
            region = RGN_ABSENT;
        else if (int'(offset) < SFR_SPAN)
            region = RGN_SFR;
        else
            region = RGN_GPR;
    end

endmodule

// File: rtl/rf_status_reg.sv
// Status byte holding the bank-select field; reachable from every bank.
// Assumes: writes come only through the decoded status enable.
module rf_status_reg #(
    parameter int DATA_W   = 8,
    parameter int BANK_W   = 2,
    parameter int BANK_LSB = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] status_q,
    output logic [BANK_W-1:0] bank_sel
);

    // Hold the status byte, cleared to bank 0 on reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= '0;
        else if (we)
            status_q <= wdata;
    end

    // Extract the bank-select field
    assign bank_sel = status_q[BANK_LSB +: BANK_W];

    // R4: a status write lands whole on the next cycle
    p_status_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> status_q == $past(wdata));

    // R3: without a status write the bank does not move
    p_bank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(bank_sel));

endmodule

// File: rtl/rf_sfr_store.sv
// Per-bank special-function storage, cleared on reset, one copy per implemented bank.
// Assumes: caller raises we only for implemented banks; unused bank slots read zero.
module rf_sfr_store #(
    parameter int DATA_W    = 8,
    parameter int BANK_W    = 2,
    parameter int NUM_BANKS = 3,
    parameter int SFR_SPAN  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [BANK_W-1:0] bank,
    input  logic [$clog2(SFR_SPAN)-1:0] idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int BANK_SLOTS = 1 << BANK_W;

    logic [DATA_W-1:0] bank_rd [BANK_SLOTS];

    for (genvar b = 0; b < BANK_SLOTS; b++) begin : g_bank
        if (b < NUM_BANKS) begin : g_impl
            logic [DATA_W-1:0] regs [SFR_SPAN];

            // Store one bank's SFR bytes, clearing them on reset
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < SFR_SPAN; i++)
                        regs[i] <= '0;
                end else if (we && int'(bank) == b) begin
                    regs[idx] <= wdata;
                end
            end

            // Present this bank's addressed byte
            assign bank_rd[b] = regs[idx];
        end else begin : g_absent
            assign bank_rd[b] = '0;
        end
    end

    // Select the addressed bank's byte
    assign rdata = bank_rd[bank];

endmodule

// File: rtl/rf_ram.sv
// Plain synchronous-write, combinational-read storage without reset.
// Assumes: contents are undefined until written.
module rf_ram #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Write one byte at the clock edge
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // Read the addressed byte combinationally
    assign rdata = mem[raddr];

endmodule

// File: rtl/banked_regfile.sv
// Banked data-memory addressing: extends a 7-bit offset with two status bank
// bits, mirrors the status byte and a shared window into every bank, and
// blanks absent banks.
// Assumes: one access per cycle; the same reg_addr is used for read and write.
module banked_regfile
    import banked_rf_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 7,
    parameter int BANK_W      = 2,
    parameter int NUM_BANKS   = 3,
    parameter int SFR_SPAN    = 32,
    parameter int SHARED_BASE = 112,
    parameter int STATUS_OFS  = 3,
    parameter int BANK_LSB    = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [DATA_W-1:0]        rd_data,
    output logic [DATA_W-1:0]        status_q,
    output logic [BANK_W+ADDR_W-1:0] dbg_phys_addr
);

    localparam int BANK_SPAN   = 1 << ADDR_W;
    localparam int SHARED_SIZE = BANK_SPAN - SHARED_BASE;
    localparam int GPR_SPAN    = SHARED_BASE - SFR_SPAN;
    localparam int GPR_DEPTH   = NUM_BANKS * GPR_SPAN;
    localparam int GPR_AW      = $clog2(GPR_DEPTH);
    localparam int SH_AW       = $clog2(SHARED_SIZE);
    localparam int SFR_AW      = $clog2(SFR_SPAN);

    logic [BANK_W-1:0] bank_sel;
    region_e           region;
    logic              status_we, shared_we, sfr_we, gpr_we;
    logic [DATA_W-1:0] sfr_rd, gpr_rd, shared_rd;
    logic [GPR_AW-1:0] gpr_idx;
    logic [SH_AW-1:0]  sh_idx;
    logic [SFR_AW-1:0] sfr_idx;
    int                gpr_lin;

    rf_status_reg #(
        .DATA_W  (DATA_W),
        .BANK_W  (BANK_W),
        .BANK_LSB(BANK_LSB)
    ) status_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (status_we),
        .wdata   (wr_data),
        .status_q(status_q),
        .bank_sel(bank_sel)
    );

    rf_addr_decode #(
        .ADDR_W     (ADDR_W),
        .BANK_W     (BANK_W),
        .NUM_BANKS  (NUM_BANKS),
        .SFR_SPAN   (SFR_SPAN),
        .SHARED_BASE(SHARED_BASE),
        .STATUS_OFS (STATUS_OFS)
    ) decode_i (
        .bank  (bank_sel),
        .offset(reg_addr),
        .region(region)
    );

    // Steer the single write to the one region that owns the address
    always_comb begin
        status_we = wr_en && (region == RGN_STATUS);
        shared_we = wr_en && (region == RGN_SHARED);
        sfr_we    = wr_en && (region == RGN_SFR);
        gpr_we    = wr_en && (region == RGN_GPR);
    end

    // Form per-region storage indices from bank and offset
    always_comb begin
        gpr_lin = int'(bank_sel) * GPR_SPAN + int'(reg_addr) - SFR_SPAN;
        gpr_idx = (region == RGN_GPR) ? GPR_AW'(gpr_lin) : '0;
        sh_idx  = SH_AW'(reg_addr);
        sfr_idx = SFR_AW'(reg_addr);
    end

    rf_sfr_store #(
        .DATA_W   (DATA_W),
        .BANK_W   (BANK_W),
        .NUM_BANKS(NUM_BANKS),
        .SFR_SPAN (SFR_SPAN)
    ) sfr_i (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (sfr_we),
        .bank (bank_sel),
        .idx  (sfr_idx),
        .wdata(wr_data),
        .rdata(sfr_rd)
    );

    rf_ram #(
        .DATA_W(DATA_W),
        .DEPTH (GPR_DEPTH)
    ) gpr_i (
        .clk  (clk),
        .we   (gpr_we),
        .waddr(gpr_idx),
        .wdata(wr_data),
        .raddr(gpr_idx),
        .rdata(gpr_rd)
    );

    rf_ram #(
        .DATA_W(DATA_W),
        .DEPTH (SHARED_SIZE)
    ) shared_i (
        .clk  (clk),
        .we   (shared_we),
        .waddr(sh_idx),
        .wdata(wr_data),
        .raddr(sh_idx),
        .rdata(shared_rd)
    );

    // Return the byte of whichever region the address resolved to
    always_comb begin
        unique case (region)
            RGN_STATUS: rd_data = status_q;
            RGN_SHARED: rd_data = shared_rd;
            RGN_SFR:    rd_data = sfr_rd;
            RGN_GPR:    rd_data = gpr_rd;
            default:    rd_data = '0;
        endcase
    end

    // Expose the physical address of the current access
    assign dbg_phys_addr = {bank_sel, reg_addr};

    // R8: absent banks read as zero
    p_absent_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        region == RGN_ABSENT |-> rd_data == '0);

    // R8: absent banks never reach any storage
    p_absent_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        region == RGN_ABSENT |-> !(status_we || shared_we || sfr_we || gpr_we));

    // R6: at most one storage target is written per cycle
    p_one_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({status_we, shared_we, sfr_we, gpr_we}));

    // R2: a status write moves the debug bank field on the next cycle
    p_phys_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(reg_addr) == STATUS_OFS)
        |=> dbg_phys_addr[ADDR_W +: BANK_W] == $past(wr_data[BANK_LSB +: BANK_W]));

    // R5: a shared write is read back at the same offset in any bank
    p_shared_readback_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(reg_addr) >= SHARED_BASE) ##1 (reg_addr == $past(reg_addr))
        |-> rd_data == $past(wr_data));

endmodule

// File: tb/banked_regfile_tb.sv
`timescale 1ns/1ps
module banked_regfile_tb_top;

    localparam int NB       = 3;
    localparam int HALF     = 10;
    localparam int WD_LIMIT = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [6:0] reg_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [7:0] status_q;
    logic [8:0] dbg_phys_addr;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    // Behavioural reference state
    logic [7:0] m_status;
    logic [7:0] m_shared [16];
    bit         m_sh_known [16];
    logic [7:0] m_bank [4][128];
    bit         m_known [4][128];

    banked_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd_data), .status_q(status_q),
        .dbg_phys_addr(dbg_phys_addr)
    );

    always #HALF clk = ~clk;

    task automatic check(input logic [8:0] act, input logic [8:0] exp, input string req);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s addr=%02h actual=%03h expected=%03h", req, reg_addr, act, exp);
        end
    endtask

    // Drive one access, compare with the model before the edge, then advance the model
    task automatic step(input bit we, input logic [6:0] a, input logic [7:0] d, input string tag);
        int         bank;
        logic [7:0] exp;
        bit         known;
        string      t;
        @(negedge clk);
        wr_en = we; reg_addr = a; wr_data = d;
        #2;
        bank = int'(m_status[6:5]);
        if (a == 7'h03) begin
            exp = m_status; known = 1; t = "R4";
        end else if (a >= 7'h70) begin
            exp = m_shared[a - 7'h70]; known = m_sh_known[a - 7'h70]; t = "R5";
        end else if (bank >= NB) begin
            exp = 8'h00; known = 1; t = "R8";
        end else begin
            exp = m_bank[bank][a]; known = m_known[bank][a];
            t = (a < 7'h20) ? "R6" : "R7";
        end
        if (tag != "") t = tag;
        if (known) check({1'b0, rd_data}, {1'b0, exp}, t);
        check(dbg_phys_addr, {m_status[6:5], a}, "R2");
        check({1'b0, status_q}, {1'b0, m_status}, "R4");
        if (we) begin
            if (a == 7'h03) m_status = d;
            else if (a >= 7'h70) begin
                m_shared[a - 7'h70] = d; m_sh_known[a - 7'h70] = 1;
            end else if (bank < NB) begin
                m_bank[bank][a] = d; m_known[bank][a] = 1;
            end
        end
    endtask

    task automatic set_bank(input int b);
        step(1'b1, 7'h03, 8'(b << 5), "R4");
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R9 actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) m_sh_known[i] = 0;
        for (int b = 0; b < 4; b++)
            for (int o = 0; o < 128; o++) m_known[b][o] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // Model reset state (R1)
        m_status = 8'h00;
        for (int b = 0; b < NB; b++)
            for (int o = 0; o < 32; o++) begin
                m_bank[b][o] = 8'h00; m_known[b][o] = 1;
            end

        // R1: reset clears status and SFRs
        step(1'b0, 7'h03, 8'h00, "R1");
        step(1'b0, 7'h05, 8'h00, "R1");
        step(1'b0, 7'h1F, 8'h00, "R1");

        // Fill every bank, including the absent one (R8 drops those writes)
        for (int b = 0; b < 4; b++) begin
            set_bank(b);
            for (int o = 0; o < 128; o++)
                if (o != 3) step(1'b1, 7'(o), 8'((o * 7 + b * 41 + 3) & 8'hFF), "");
        end
        // Read every offset of every bank back (R5..R9)
        for (int b = 0; b < 4; b++) begin
            set_bank(b);
            for (int o = 0; o < 128; o++) step(1'b0, 7'(o), 8'h00, "");
        end

        // R3: switch bank and read in the same cycle, then the next cycle
        set_bank(0);
        step(1'b1, 7'h20, 8'hA5, "R9");
        set_bank(1);
        step(1'b1, 7'h20, 8'h5A, "R9");
        step(1'b1, 7'h03, 8'h00, "R3");
        step(1'b0, 7'h20, 8'h00, "R3");
        step(1'b1, 7'h03, 8'h20, "R3");
        step(1'b0, 7'h20, 8'h00, "R3");
        // R8: absent bank write then check the real banks
        set_bank(3);
        step(1'b1, 7'h20, 8'hFF, "R8");
        step(1'b0, 7'h20, 8'h00, "R8");
        step(1'b1, 7'h75, 8'h3C, "R5");
        set_bank(2);
        step(1'b0, 7'h75, 8'h00, "R5");
        step(1'b0, 7'h20, 8'h00, "R7");

        // Random mix of bank switches, reads and writes
        for (int n = 0; n < 4000; n++) begin
            int         r = int'($urandom_range(0, 99));
            logic [6:0] a;
            if (r < 8) step(1'b1, 7'h03, 8'($urandom), "");
            else begin
                a = (r < 40) ? 7'($urandom_range(0, 31)) :
                    (r < 80) ? 7'($urandom_range(32, 111)) : 7'($urandom_range(112, 127));
                step(r[0], a, 8'($urandom), "");
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule